// File: doc/BRIEF.md
# Register Rename Map Table

This block keeps, for every architectural register, a record of whether an in-flight instruction will produce that register's next value and, if so, which reorder-buffer slot holds it. Each cycle two source operands are looked up. A lookup that returns a valid entry tells the operand fetch logic to read the reorder buffer at the returned tag. A lookup that returns an invalid entry means no in-flight producer exists, so the value comes from the architectural register file.

In the same cycle, one destination register can be renamed to a newly allocated reorder-buffer tag. Retirement notices remove a mapping once its producer has committed. The table has two ways to recover from misspeculation. A flush invalidates every entry, so all registers fall back to the architectural file. A single whole-table checkpoint can also be saved at a branch and reloaded when that branch resolves wrong.

Top module: `rename_map_table`

## Requirements
- R1: After a synchronous active-low reset, every register looks up as invalid on both ports.
- R2: The two lookup ports are independent and combinational. Whenever both ports name the same register, they return an identical valid bit and tag.
- R3: A rename write (`dst_we`=1) makes the named register look up as valid with `dst_tag` from the next cycle. Other registers are left unchanged.
- R4: A lookup made in the same cycle as a rename write to the same register returns the mapping from before the write.
- R5: A retirement whose tag equals the stored tag of a valid entry for `retire_id` makes that register invalid from the next cycle.
- R6: A retirement whose tag differs from the stored tag, or that targets an invalid entry, leaves the table unchanged.
- R7: When a rename write and a retirement target the same register in one cycle, the rename write's mapping is kept.
- R8: A flush (`flush`=1) makes every register invalid from the next cycle. It overrides a rename write and a retirement in the same cycle.
- R9: `ckpt_take`=1 saves the table as it stands at the start of that cycle, with that cycle's retirement applied and that cycle's rename write excluded. A later `ckpt_restore`=1 makes the table equal to the saved copy from the next cycle.
- R10: A restore overrides a flush, a rename write and a retirement issued in the same cycle.
- R11: A retirement with a matching tag also invalidates the corresponding entry of the saved copy, so a later restore does not bring back a retired mapping.
- R12: A save request issued in the same cycle as a restore is ignored, and the saved copy stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a_id | input | 3 | Register looked up by port A |
| src_a_valid | output | 1 | Port A: value lives in the reorder buffer |
| src_a_tag | output | 4 | Port A: reorder-buffer tag of the producer |
| src_b_id | input | 3 | Register looked up by port B |
| src_b_valid | output | 1 | Port B: value lives in the reorder buffer |
| src_b_tag | output | 4 | Port B: reorder-buffer tag of the producer |
| dst_we | input | 1 | Rename write enable |
| dst_id | input | 3 | Destination register being renamed |
| dst_tag | input | 4 | Newly allocated reorder-buffer tag |
| retire_en | input | 1 | Retirement notice valid |
| retire_id | input | 3 | Destination register of the retiring instruction |
| retire_tag | input | 4 | Reorder-buffer tag of the retiring instruction |
| flush | input | 1 | Invalidate every mapping |
| ckpt_take | input | 1 | Save the whole table |
| ckpt_restore | input | 1 | Reload the saved table |

## Verification
A corrupted entry has only one visible effect: the lookup of that register returns a wrong valid bit or a wrong tag. The error therefore shows up in the first cycle after the faulty update, and only when a port names that register. For this reason, every register is swept through both ports after every operation. A wrong saved copy stays hidden until a restore. The bench therefore pairs each save with later renames, retirements and a restore, and compares all entries afterwards. A long pseudo-random run, checked each cycle against an arithmetic model, covers operations that coincide in the same cycle.

// File: rtl/rename_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the rename map table.
// Assumes: nothing; holds defaults and the update-kind encoding only.
package rename_pkg;
    localparam int DEF_ARCH_REGS   = 8;
    localparam int DEF_ROB_ENTRIES = 16;

    // Kind of update applied to the live copy of one entry in a cycle.
    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_RENAME  = 2'd1,
        UPD_CLEAR   = 2'd2,
        UPD_RESTORE = 2'd3
    } upd_kind_e;
endpackage

// File: rtl/rename_map_entry.sv
`timescale 1ns/1ps
// One register's mapping: a live (valid, tag) pair and its saved copy.
// Assumes: wr_sel and ret_sel are already decoded for this register;
// priority is restore > flush > rename > retirement clear.
module rename_map_entry
    import rename_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             ret_sel,
    input  logic [TAG_W-1:0] ret_tag,
    input  logic             flush,
    input  logic             take,
    input  logic             restore,
    output logic             map_valid,
    output logic [TAG_W-1:0] map_tag
);
    logic             live_v, snap_v;
    logic [TAG_W-1:0] live_t, snap_t;
    logic             live_ret, snap_ret;
    upd_kind_e        live_kind;

    // Detect a retirement that matches the stored producer of each copy.
    always_comb begin
        live_ret = ret_sel && live_v && (live_t == ret_tag);
        snap_ret = ret_sel && snap_v && (snap_t == ret_tag);
    end

    // Pick the single update that wins for the live copy this cycle.
    always_comb begin
        if (restore)       live_kind = UPD_RESTORE;
        else if (flush)    live_kind = UPD_CLEAR;
        else if (wr_sel)   live_kind = UPD_RENAME;
        else if (live_ret) live_kind = UPD_CLEAR;
        else               live_kind = UPD_HOLD;
    end

    // Live copy register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_v <= 1'b0;
            live_t <= '0;
        end else begin
            case (live_kind)
                UPD_RESTORE: begin
                    live_v <= snap_v && !snap_ret;
                    live_t <= snap_t;
                end
                UPD_CLEAR:  live_v <= 1'b0;
                UPD_RENAME: begin
                    live_v <= 1'b1;
                    live_t <= wr_tag;
                end
                default: ;
            endcase
        end
    end

    // Saved copy register: capture on take, otherwise track retirements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_v <= 1'b0;
            snap_t <= '0;
        end else if (take && !restore) begin
            snap_v <= live_v && !live_ret;
            snap_t <= live_t;
        end else if (snap_ret) begin
            snap_v <= 1'b0;
        end
    end

    assign map_valid = live_v;
    assign map_tag   = live_t;
endmodule

// File: rtl/rename_read_port.sv
`timescale 1ns/1ps
// Combinational lookup of one register in the live table.
// Assumes: ids at or above NUM_REGS return an invalid, zero-tag result.
module rename_read_port #(
    parameter int NUM_REGS = 8,
    parameter int TAG_W    = 4,
    localparam int ID_W    = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0]            valid_vec,
    input  logic [NUM_REGS-1:0][TAG_W-1:0] tag_vec,
    input  logic [ID_W-1:0]                rd_id,
    output logic                           rd_valid,
    output logic [TAG_W-1:0]               rd_tag
);
    // Select the addressed entry.
    always_comb begin
        rd_valid = 1'b0;
        rd_tag   = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_id == ID_W'(i)) begin
                rd_valid = valid_vec[i];
                rd_tag   = tag_vec[i];
            end
        end
    end
endmodule

// File: rtl/rename_map_table.sv
`timescale 1ns/1ps
// Register rename map table: two lookups, one rename write, one
// retirement notice, flush and a single whole-table checkpoint per cycle.
// Assumes: lookups see the table before this cycle's updates.
module rename_map_table
    import rename_pkg::*;
#(
    parameter int ARCH_REGS   = DEF_ARCH_REGS,
    parameter int ROB_ENTRIES = DEF_ROB_ENTRIES,
    localparam int ARCH_W     = $clog2(ARCH_REGS),
    localparam int TAG_W      = $clog2(ROB_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ARCH_W-1:0] src_a_id,
    output logic              src_a_valid,
    output logic [TAG_W-1:0]  src_a_tag,
    input  logic [ARCH_W-1:0] src_b_id,
    output logic              src_b_valid,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              dst_we,
    input  logic [ARCH_W-1:0] dst_id,
    input  logic [TAG_W-1:0]  dst_tag,
    input  logic              retire_en,
    input  logic [ARCH_W-1:0] retire_id,
    input  logic [TAG_W-1:0]  retire_tag,
    input  logic              flush,
    input  logic              ckpt_take,
    input  logic              ckpt_restore
);
    logic [ARCH_REGS-1:0]            map_valid;
    logic [ARCH_REGS-1:0][TAG_W-1:0] map_tag;

    // One entry per architectural register, with its own decode.
    for (genvar g = 0; g < ARCH_REGS; g++) begin : g_entry
        rename_map_entry #(.TAG_W(TAG_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (dst_we && (dst_id == ARCH_W'(g))),
            .wr_tag    (dst_tag),
            .ret_sel   (retire_en && (retire_id == ARCH_W'(g))),
            .ret_tag   (retire_tag),
            .flush     (flush),
            .take      (ckpt_take),
            .restore   (ckpt_restore),
            .map_valid (map_valid[g]),
            .map_tag   (map_tag[g])
        );
    end

    rename_read_port #(.NUM_REGS(ARCH_REGS), .TAG_W(TAG_W)) u_port_a (
        .valid_vec (map_valid),
        .tag_vec   (map_tag),
        .rd_id     (src_a_id),
        .rd_valid  (src_a_valid),
        .rd_tag    (src_a_tag)
    );

    rename_read_port #(.NUM_REGS(ARCH_REGS), .TAG_W(TAG_W)) u_port_b (
        .valid_vec (map_valid),
        .tag_vec   (map_tag),
        .rd_id     (src_b_id),
        .rd_valid  (src_b_valid),
        .rd_tag    (src_b_tag)
    );
endmodule

// File: rtl/rename_map_table_chk.sv
`timescale 1ns/1ps
// Port-level properties of the rename map table, bound to the top.
// Assumes: synchronous active-low reset.
module rename_map_table_chk #(
    parameter int ARCH_W = 3,
    parameter int TAG_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ARCH_W-1:0] src_a_id,
    input logic              src_a_valid,
    input logic [TAG_W-1:0]  src_a_tag,
    input logic [ARCH_W-1:0] src_b_id,
    input logic              src_b_valid,
    input logic [TAG_W-1:0]  src_b_tag,
    input logic              dst_we,
    input logic [ARCH_W-1:0] dst_id,
    input logic [TAG_W-1:0]  dst_tag,
    input logic              retire_en,
    input logic [ARCH_W-1:0] retire_id,
    input logic [TAG_W-1:0]  retire_tag,
    input logic              flush,
    input logic              ckpt_restore
);
    // R1: a reset cycle leaves both ports reporting invalid.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!src_a_valid && !src_b_valid));

    // R2: both ports agree whenever they address the same register.
    assert_ports_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_id == src_b_id) |-> (src_a_valid == src_b_valid && src_a_tag == src_b_tag));

    // R3: a rename write is visible the next cycle.
    assert_rename_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && !flush && !ckpt_restore) |=>
        ((src_a_id != $past(dst_id)) || (src_a_valid && src_a_tag == $past(dst_tag))));

    // R5: a matching retirement removes the mapping.
    assert_retire_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_en && src_a_valid && src_a_id == retire_id && src_a_tag == retire_tag &&
         !ckpt_restore && !(dst_we && dst_id == retire_id)) |=>
        ((src_a_id != $past(retire_id)) || !src_a_valid));

    // R6: a non-matching retirement keeps the mapping.
    assert_retire_stale_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_en && src_a_valid && src_a_id == retire_id && src_a_tag != retire_tag &&
         !ckpt_restore && !flush && !(dst_we && dst_id == retire_id)) |=>
        ((src_a_id != $past(src_a_id)) || (src_a_valid && src_a_tag == $past(src_a_tag))));

    // R8: a flush without restore empties the table.
    assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !ckpt_restore) |=> (!src_a_valid && !src_b_valid));
endmodule

bind rename_map_table rename_map_table_chk #(.ARCH_W(ARCH_W), .TAG_W(TAG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_a_id     (src_a_id),
    .src_a_valid  (src_a_valid),
    .src_a_tag    (src_a_tag),
    .src_b_id     (src_b_id),
    .src_b_valid  (src_b_valid),
    .src_b_tag    (src_b_tag),
    .dst_we       (dst_we),
    .dst_id       (dst_id),
    .dst_tag      (dst_tag),
    .retire_en    (retire_en),
    .retire_id    (retire_id),
    .retire_tag   (retire_tag),
    .flush        (flush),
    .ckpt_restore (ckpt_restore)
);

// File: tb/test_rename_map_table.sv
`timescale 1ns/100ps
module test_rename_map_table;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] src_a_id, src_b_id, dst_id, retire_id;
    logic       src_a_valid, src_b_valid;
    logic [3:0] src_a_tag, src_b_tag, dst_tag, retire_tag;
    logic       dst_we, retire_en, flush, ckpt_take, ckpt_restore;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Arithmetic model of the table and its saved copy.
    logic       m_v [8];
    logic [3:0] m_t [8];
    logic       s_v [8];
    logic [3:0] s_t [8];

    always #5 clk = ~clk;

    rename_map_table i_rename_map_table (
        .clk(clk), .rst_n(rst_n),
        .src_a_id(src_a_id), .src_a_valid(src_a_valid), .src_a_tag(src_a_tag),
        .src_b_id(src_b_id), .src_b_valid(src_b_valid), .src_b_tag(src_b_tag),
        .dst_we(dst_we), .dst_id(dst_id), .dst_tag(dst_tag),
        .retire_en(retire_en), .retire_id(retire_id), .retire_tag(retire_tag),
        .flush(flush), .ckpt_take(ckpt_take), .ckpt_restore(ckpt_restore)
    );

    task automatic chk(input string req, input logic av, input logic [3:0] at,
                       input logic ev, input logic [3:0] et);
        n_run++;
        if (av !== ev || (ev && at !== et)) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b tag=%0d, expected valid=%0b tag=%0d",
                     req, av, at, ev, et);
        end
    endtask

    task automatic idle_ctrl();
        dst_we = 0; dst_id = 0; dst_tag = 0;
        retire_en = 0; retire_id = 0; retire_tag = 0;
        flush = 0; ckpt_take = 0; ckpt_restore = 0;
    endtask

    // Sweep all registers through both ports and compare with the model.
    task automatic sweep(input string req);
        for (int i = 0; i < 8; i++) begin
            src_a_id = 3'(i);
            src_b_id = 3'(7 - i);
            #0.4;
            chk(req, src_a_valid, src_a_tag, m_v[i], m_t[i]);
            chk(req, src_b_valid, src_b_tag, m_v[7-i], m_t[7-i]);
        end
    endtask

    // Model update following R3, R5-R12.
    task automatic model_step();
        logic       lv [8];
        logic       sv [8];
        for (int i = 0; i < 8; i++) begin
            lv[i] = m_v[i];
            sv[i] = s_v[i];
            if (retire_en && retire_id == 3'(i)) begin
                if (lv[i] && m_t[i] == retire_tag) lv[i] = 0;
                if (sv[i] && s_t[i] == retire_tag) sv[i] = 0;
            end
        end
        for (int i = 0; i < 8; i++) begin
            if (ckpt_restore) begin
                m_v[i] = sv[i]; m_t[i] = s_t[i];
            end else if (flush) begin
                m_v[i] = 0;
            end else if (dst_we && dst_id == 3'(i)) begin
                m_v[i] = 1; m_t[i] = dst_tag;
            end else begin
                m_v[i] = lv[i];
            end
            if (ckpt_take && !ckpt_restore) begin
                s_v[i] = lv[i]; s_t[i] = (i < 8) ? m_t_old(i) : 4'd0;
            end else begin
                s_v[i] = sv[i];
            end
        end
    endtask

    logic [3:0] t_old [8];
    function automatic logic [3:0] m_t_old(input int i);
        return t_old[i];
    endfunction

    // One clocked operation: drive at negedge, update model, then sweep.
    task automatic op(input logic we, input logic [2:0] did, input logic [3:0] dtag,
                      input logic re, input logic [2:0] rid, input logic [3:0] rtag,
                      input logic fl, input logic tk, input logic rs, input string req);
        @(negedge clk);
        dst_we = we; dst_id = did; dst_tag = dtag;
        retire_en = re; retire_id = rid; retire_tag = rtag;
        flush = fl; ckpt_take = tk; ckpt_restore = rs;
        @(posedge clk);
        for (int i = 0; i < 8; i++) t_old[i] = m_t[i];
        model_step();
        #1;
        idle_ctrl();
        sweep(req);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got no finish, expected finish");
        if (!done) $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        idle_ctrl();
        src_a_id = 0; src_b_id = 0;
        rst_n = 0;
        for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_t[i] = 0; s_v[i] = 0; s_t[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        sweep("R1");

        // R3: rename every register with a computed tag.
        for (int i = 0; i < 8; i++)
            op(1, 3'(i), 4'(i + 3), 0, 0, 0, 0, 0, 0, "R3");
        // R2: redefine register 2, both ports see the younger tag.
        op(1, 3'd2, 4'd14, 0, 0, 0, 0, 0, 0, "R2");

        // R4: same-cycle lookup of the register being renamed sees the old tag.
        @(negedge clk);
        dst_we = 1; dst_id = 3'd5; dst_tag = 4'd1;
        src_a_id = 3'd5; src_b_id = 3'd5;
        #1;
        chk("R4", src_a_valid, src_a_tag, 1'b1, 4'd8);
        chk("R4", src_b_valid, src_b_tag, 1'b1, 4'd8);
        @(posedge clk);
        for (int i = 0; i < 8; i++) t_old[i] = m_t[i];
        model_step();
        #1 idle_ctrl();
        sweep("R4");

        // R5: matching retirement clears; R6: stale tag and invalid target keep.
        op(0, 0, 0, 1, 3'd0, 4'd3, 0, 0, 0, "R5");
        op(0, 0, 0, 1, 3'd2, 4'd5, 0, 0, 0, "R6");
        op(0, 0, 0, 1, 3'd0, 4'd3, 0, 0, 0, "R6");
        // R7: rename and retirement on the same register.
        op(1, 3'd4, 4'd11, 1, 3'd4, 4'd7, 0, 0, 0, "R7");

        // R8: flush beats a same-cycle rename.
        op(1, 3'd6, 4'd2, 0, 0, 0, 1, 0, 0, "R8");

        // R9: rebuild, save with a same-cycle rename and retirement, then restore.
        for (int i = 0; i < 8; i++)
            op(1, 3'(i), 4'(15 - i), 0, 0, 0, 0, 0, 0, "R9");
        op(1, 3'd1, 4'd0, 1, 3'd3, 4'd12, 0, 1, 0, "R9");
        op(1, 3'd7, 4'd4, 0, 0, 0, 0, 0, 0, "R9");
        // R11: retirement that also hits the saved copy.
        op(0, 0, 0, 1, 3'd5, 4'd10, 0, 0, 0, "R11");
        op(0, 0, 0, 0, 0, 0, 1, 0, 0, "R9");
        // R10: restore beats flush and rename; R12: take ignored with restore.
        op(1, 3'd0, 4'd9, 1, 3'd6, 4'd9, 1, 1, 1, "R10");
        op(1, 3'd2, 4'd1, 0, 0, 0, 0, 0, 0, "R12");
        op(0, 0, 0, 0, 0, 0, 0, 0, 1, "R12");

        // R2: pseudo-random mix of all operations against the model.
        lf = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op(lf[0], lf[3:1], lf[7:4], lf[8], lf[11:9], lf[15:12] ^ lf[7:4],
               lf[15:11] == 5'd0, lf[6:3] == 4'd1, lf[14:10] == 5'd3, "R2");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule